// File: doc/BRIEF.md
# Persistent threshold fault qualifier

This block watches a stream of sampled measurements and decides when a limit violation is real enough to shut the power stage down. Each strobe carries a supply-voltage sample and a temperature sample. The voltage samples feed a boxcar moving average over a power-of-two number of samples. The block compares that average against a lower and an upper limit. An out-of-window average has to persist for a programmable number of consecutive strobes before it counts as a fault, so brief dips and surges on the supply are filtered out. The temperature sample takes a different path: it is compared raw against a maximum setpoint and trips on the first strobe that exceeds it.

Any fault sets a sticky cause bit and drives the latched shutdown output that turns the PWM outputs off. Software releases the latch with a clear pulse. The clear only takes effect once the measured conditions are back in range.

Top module: `persist_fault_qual`

## Requirements
- R1: `avg_value` equals the integer floor of the mean of the last 2^AVG_LOG2 voltage samples (8 by default). It is updated on each cycle with `smp_vld` high and is visible the cycle after. The first strobe after reset fills the whole window with that sample.
- R2: An average counts as out of window only when it is strictly below `lim_under` or strictly above `lim_over`. An average equal to either limit is in window.
- R3: A persistence count goes up by one (saturating) on every strobe whose new average is out of window. A voltage fault trips on the strobe where the count reaches `persist_len`, and a value of 0 acts as 1. Shorter runs raise no fault.
- R4: A strobe whose new average is in window sets the persistence count back to zero, so an interrupted run starts again from one.
- R5: A strobe whose `smp_temp` is strictly greater than `lim_temp` sets `cause_ot` on the next cycle. A value equal to the setpoint does not.
- R6: On a voltage trip, `cause_uv` is set if the average was below `lim_under`, and `cause_ov` is set if it was above `lim_over`.
- R7: `pwm_off` is high exactly while at least one cause bit is set. Cause bits stay set until a clear is accepted.
- R8: A clear pulse is accepted only when the persistence count is zero and the last strobed temperature was not above the setpoint. Otherwise the pulse is ignored. A clear that is accepted in the same cycle as a new trip loses to the trip.
- R9: Cycles without `smp_vld` change neither the average, the persistence count nor the cause bits, apart from an accepted clear.
- R10: After reset, `pwm_off`, every cause bit and `avg_value` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe, one cycle per sample |
| smp_volt | input | DATA_W | Voltage sample |
| smp_temp | input | DATA_W | Temperature sample |
| lim_under | input | DATA_W | Lowest in-window average |
| lim_over | input | DATA_W | Highest in-window average |
| lim_temp | input | DATA_W | Highest allowed temperature |
| persist_len | input | PERS_W | Consecutive out-of-window strobes needed to trip |
| flt_clear | input | 1 | Request to release the latched fault |
| pwm_off | output | 1 | Latched shutdown command to the PWM stage |
| cause_uv | output | 1 | Sticky under-voltage cause |
| cause_ov | output | 1 | Sticky over-voltage cause |
| cause_ot | output | 1 | Sticky over-temperature cause |
| avg_value | output | DATA_W | Current moving average |

## Verification
The assertions assume that `lim_under` is not above `lim_over`, so at most one voltage cause can be set by a single trip. They also assume that limits and `persist_len` are stable while samples stream, and that `flt_clear` is a single-cycle pulse. The random stimulus changes limits and `persist_len` only at reset points, always picks the upper limit above the lower one, and drops every strobe and clear back to zero after one cycle. Directed sequences place averages exactly on both limits, temperatures exactly on the setpoint, runs one short of the persistence length, and runs interrupted by one in-window sample.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  typedef struct packed {
    logic uv;
    logic ov;
    logic ot;
  } pfq_cause_t;

endpackage

// File: rtl/pfq_avg.sv
module pfq_avg #(
  parameter int DATA_W   = 12,
  parameter int AVG_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] avg_q,
  output logic [DATA_W-1:0] avg_nxt
);

  localparam int DEPTH = 1 << AVG_LOG2;
  localparam int SUM_W = DATA_W + AVG_LOG2;

  function automatic logic [DATA_W-1:0] mean_of(input logic [SUM_W-1:0] s);
    return s[SUM_W-1:AVG_LOG2];
  endfunction

  logic [DEPTH-1:0][DATA_W-1:0] hist_q;
  logic [SUM_W-1:0]             sum_q, sum_nxt, din_ext;
  logic                         primed_q;

  assign din_ext = SUM_W'(din);

  // First strobe fills the window; afterwards add newest, drop oldest.
  always_comb begin
    if (primed_q) sum_nxt = sum_q + din_ext - SUM_W'(hist_q[DEPTH-1]);
    else          sum_nxt = din_ext << AVG_LOG2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q   <= '0;
      sum_q    <= '0;
      primed_q <= 1'b0;
    end else if (vld) begin
      hist_q[0] <= din;
      for (int i = 1; i < DEPTH; i++)
        hist_q[i] <= primed_q ? hist_q[i-1] : din;
      sum_q    <= sum_nxt;
      primed_q <= 1'b1;
    end
  end

  assign avg_q   = mean_of(sum_q);
  assign avg_nxt = mean_of(sum_nxt);

endmodule

// File: rtl/pfq_persist.sv
module pfq_persist #(
  parameter int DATA_W = 12,
  parameter int PERS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [DATA_W-1:0] avg_nxt,
  input  logic [DATA_W-1:0] lim_under,
  input  logic [DATA_W-1:0] lim_over,
  input  logic [PERS_W-1:0] persist_len,
  output logic              win_lo,
  output logic              win_hi,
  output logic              win_out,
  output logic              trip,
  output logic [PERS_W-1:0] cnt_q
);

  localparam logic [PERS_W-1:0] CNT_MAX = '1;

  function automatic logic [PERS_W-1:0] sat_inc(input logic [PERS_W-1:0] c);
    return (c == CNT_MAX) ? CNT_MAX : c + 1'b1;
  endfunction

  logic [PERS_W-1:0] cnt_inc;

  assign win_lo  = avg_nxt < lim_under;
  assign win_hi  = avg_nxt > lim_over;
  assign win_out = win_lo | win_hi;
  assign cnt_inc = sat_inc(cnt_q);
  // persist_len of zero is met by the first out-of-window strobe
  assign trip    = vld & win_out & (cnt_inc >= persist_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (vld) cnt_q <= win_out ? cnt_inc : '0;
  end

endmodule

// File: rtl/pfq_latch.sv
module pfq_latch
  import pfq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pfq_cause_t set_c,
  input  logic       clr_ok,
  output pfq_cause_t cause_q
);

  // set has priority over an accepted clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= set_c | (cause_q & ~{3{clr_ok}});
  end

endmodule

// File: rtl/persist_fault_qual.sv
module persist_fault_qual
  import pfq_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int AVG_LOG2 = 3,
  parameter int PERS_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp_volt,
  input  logic [DATA_W-1:0] smp_temp,
  input  logic [DATA_W-1:0] lim_under,
  input  logic [DATA_W-1:0] lim_over,
  input  logic [DATA_W-1:0] lim_temp,
  input  logic [PERS_W-1:0] persist_len,
  input  logic              flt_clear,
  output logic              pwm_off,
  output logic              cause_uv,
  output logic              cause_ov,
  output logic              cause_ot,
  output logic [DATA_W-1:0] avg_value
);

  function automatic logic too_hot(input logic [DATA_W-1:0] t,
                                   input logic [DATA_W-1:0] lim);
    return t > lim;
  endfunction

  logic [DATA_W-1:0] avg_nxt;
  logic              win_lo, win_hi, win_out, trip;
  logic [PERS_W-1:0] cnt_q;
  logic              temp_hot, hot_q, clr_ok;
  pfq_cause_t        set_c, cause_q;

  pfq_avg #(.DATA_W(DATA_W), .AVG_LOG2(AVG_LOG2)) u_avg (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld     (smp_vld),
    .din     (smp_volt),
    .avg_q   (avg_value),
    .avg_nxt (avg_nxt)
  );

  pfq_persist #(.DATA_W(DATA_W), .PERS_W(PERS_W)) u_persist (
    .clk         (clk),
    .rst_n       (rst_n),
    .vld         (smp_vld),
    .avg_nxt     (avg_nxt),
    .lim_under   (lim_under),
    .lim_over    (lim_over),
    .persist_len (persist_len),
    .win_lo      (win_lo),
    .win_hi      (win_hi),
    .win_out     (win_out),
    .trip        (trip),
    .cnt_q       (cnt_q)
  );

  assign temp_hot = too_hot(smp_temp, lim_temp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hot_q <= 1'b0;
    else if (smp_vld) hot_q <= temp_hot;
  end

  assign clr_ok   = flt_clear & (cnt_q == '0) & ~hot_q;
  assign set_c.uv = trip & win_lo;
  assign set_c.ov = trip & win_hi;
  assign set_c.ot = smp_vld & temp_hot;

  pfq_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_c   (set_c),
    .clr_ok  (clr_ok),
    .cause_q (cause_q)
  );

  assign cause_uv = cause_q.uv;
  assign cause_ov = cause_q.ov;
  assign cause_ot = cause_q.ot;
  assign pwm_off  = |cause_q;

endmodule

// File: rtl/persist_fault_qual_chk.sv
module persist_fault_qual_chk #(
  parameter int DATA_W = 12,
  parameter int PERS_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_vld,
  input logic              win_out,
  input logic              temp_hot,
  input logic              trip,
  input logic              clr_ok,
  input logic [PERS_W-1:0] cnt_q,
  input logic [DATA_W-1:0] avg_value,
  input logic              cause_ot,
  input logic              pwm_off
);

  AST_AVG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(avg_value)); // R9

  AST_CNT_ZERO_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && !win_out |=> cnt_q == '0); // R4

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && win_out && (cnt_q != '1) |=> cnt_q == PERS_W'($past(cnt_q) + 1'b1)); // R3

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(cnt_q)); // R9

  AST_TRIP_SETS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> pwm_off); // R3

  AST_OT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && temp_hot |=> cause_ot); // R5

  AST_OFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_off && !clr_ok |=> pwm_off); // R7

  AST_OFF_RISE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_off) |-> $past(smp_vld)); // R7

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ok && !smp_vld |=> !pwm_off); // R8

  AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_off) |-> $past(clr_ok)); // R8

endmodule

bind persist_fault_qual persist_fault_qual_chk #(.DATA_W(DATA_W), .PERS_W(PERS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_vld   (smp_vld),
  .win_out   (win_out),
  .temp_hot  (temp_hot),
  .trip      (trip),
  .clr_ok    (clr_ok),
  .cnt_q     (cnt_q),
  .avg_value (avg_value),
  .cause_ot  (cause_ot),
  .pwm_off   (pwm_off)
);

// File: tb/persist_fault_qual_tb_top.sv
module persist_fault_qual_tb_top;

  localparam int DW = 12;
  localparam int PW = 8;
  localparam int NWIN = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_vld = 1'b0;
  logic [DW-1:0] smp_volt = '0;
  logic [DW-1:0] smp_temp = '0;
  logic [DW-1:0] lim_under = '0;
  logic [DW-1:0] lim_over = '0;
  logic [DW-1:0] lim_temp = '0;
  logic [PW-1:0] persist_len = '0;
  logic          flt_clear = 1'b0;
  logic          pwm_off, cause_uv, cause_ov, cause_ot;
  logic [DW-1:0] avg_value;

  always #10 clk = ~clk;

  persist_fault_qual dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_volt(smp_volt),
    .smp_temp(smp_temp), .lim_under(lim_under), .lim_over(lim_over),
    .lim_temp(lim_temp), .persist_len(persist_len), .flt_clear(flt_clear),
    .pwm_off(pwm_off), .cause_uv(cause_uv), .cause_ov(cause_ov),
    .cause_ot(cause_ot), .avg_value(avg_value)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;
  string cur_req = "R10";

  // reference model state
  int  m_hist[NWIN];
  int  m_wp, m_cnt;
  bit  m_primed, m_hot, m_uv, m_ov, m_ot;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int m_avg();
    int s = 0;
    if (!m_primed) return 0;
    foreach (m_hist[i]) s += m_hist[i];
    return s / NWIN;
  endfunction

  task automatic model_reset();
    foreach (m_hist[i]) m_hist[i] = 0;
    m_wp = 0; m_cnt = 0; m_primed = 0; m_hot = 0;
    m_uv = 0; m_ov = 0; m_ot = 0;
  endtask

  task automatic model_step(bit v, int volt, int temp, bit clr);
    bit ok, s_uv, s_ov, s_ot;
    int a, need;
    ok = clr && (m_cnt == 0) && !m_hot;
    s_uv = 0; s_ov = 0; s_ot = 0;
    if (v) begin
      if (!m_primed) begin
        foreach (m_hist[i]) m_hist[i] = volt;
        m_primed = 1;
      end else begin
        m_hist[m_wp] = volt;
        m_wp = (m_wp + 1) % NWIN;
      end
      a = m_avg();
      if (a < lim_under || a > lim_over) begin
        if (m_cnt < 255) m_cnt++;
        need = (persist_len == 0) ? 1 : int'(persist_len);
        if (m_cnt >= need) begin
          s_uv = (a < lim_under);
          s_ov = (a > lim_over);
        end
      end else m_cnt = 0;
      m_hot = (temp > lim_temp);
      s_ot = m_hot;
    end
    if (ok) begin m_uv = 0; m_ov = 0; m_ot = 0; end
    m_uv |= s_uv; m_ov |= s_ov; m_ot |= s_ot;
  endtask

  // called at a negative edge; returns at the next negative edge
  task automatic step(bit v, int volt, int temp, bit clr);
    smp_vld = v; smp_volt = DW'(volt); smp_temp = DW'(temp); flt_clear = clr;
    @(posedge clk);
    model_step(v, volt, temp, clr);
    @(negedge clk);
    smp_vld = 0; flt_clear = 0;
    chk("R1", "avg_value", int'(avg_value), m_avg());
    chk("R6", "cause_uv", int'(cause_uv), int'(m_uv));
    chk("R6", "cause_ov", int'(cause_ov), int'(m_ov));
    chk("R5", "cause_ot", int'(cause_ot), int'(m_ot));
    chk(cur_req, "pwm_off", int'(pwm_off), int'(m_uv | m_ov | m_ot));
  endtask

  task automatic do_reset(int lo, int hi, int tl, int pl);
    rst_n = 0; smp_vld = 0; flt_clear = 0;
    lim_under = DW'(lo); lim_over = DW'(hi); lim_temp = DW'(tl); persist_len = PW'(pl);
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R10 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    // R10: reset state
    do_reset(85, 265, 100, 4);
    chk("R10", "pwm_off", int'(pwm_off), 0);
    chk("R10", "causes", int'({cause_uv, cause_ov, cause_ot}), 0);
    chk("R10", "avg_value", int'(avg_value), 0);

    // R2: averages sitting exactly on each limit stay in window
    cur_req = "R2";
    for (int i = 0; i < 10; i++) step(1, 85, 20, 0);
    chk("R2", "pwm_off at lower limit", int'(pwm_off), 0);
    do_reset(85, 265, 100, 4);
    for (int i = 0; i < 10; i++) step(1, 265, 20, 0);
    chk("R2", "pwm_off at upper limit", int'(pwm_off), 0);

    // R1: prime, then mixed values move the mean
    cur_req = "R1";
    step(1, 84, 20, 0);
    chk("R1", "mean after one low sample", int'(avg_value), (265 * 7 + 84) / 8);
    for (int i = 0; i < 8; i++) step(1, 100 + 17 * i, 20, 0);

    // R3: trips exactly on the persist_len-th out-of-window strobe
    cur_req = "R3";
    do_reset(85, 265, 100, 4);
    for (int i = 0; i < 3; i++) step(1, 300, 20, 0);
    chk("R3", "no trip after 3 of 4", int'(pwm_off), 0);
    step(1, 300, 20, 0);
    chk("R3", "trip on 4th", int'(pwm_off), 1);
    chk("R6", "over cause", int'(cause_ov), 1);
    do_reset(85, 265, 100, 0);
    step(1, 40, 20, 0);
    chk("R3", "persist_len 0 trips at once", int'(pwm_off), 1);
    chk("R6", "under cause", int'(cause_uv), 1);

    // R4: one in-window sample restarts the run
    cur_req = "R4";
    do_reset(85, 265, 100, 4);
    for (int i = 0; i < 3; i++) step(1, 300, 20, 0);
    step(1, 0, 20, 0);
    for (int i = 0; i < 3; i++) step(1, 1000, 20, 0);
    chk("R4", "no trip after restart 3", int'(pwm_off), 0);
    step(1, 1000, 20, 0);
    chk("R4", "trip after restart 4", int'(pwm_off), 1);

    // R5: temperature on the setpoint is fine, one above trips
    cur_req = "R5";
    do_reset(85, 265, 100, 4);
    step(1, 200, 100, 0);
    chk("R5", "at setpoint", int'(cause_ot), 0);
    step(1, 200, 101, 0);
    chk("R5", "above setpoint", int'(cause_ot), 1);

    // R8: clear ignored while hot, accepted once cool
    cur_req = "R8";
    step(0, 0, 0, 1);
    chk("R8", "clear while hot", int'(pwm_off), 1);
    step(1, 200, 50, 0);
    step(0, 0, 0, 1);
    chk("R8", "clear when cool", int'(pwm_off), 0);
    do_reset(85, 265, 100, 1);
    step(1, 300, 20, 0);
    step(1, 300, 20, 1);
    chk("R8", "clear while out of window", int'(pwm_off), 1);

    // R9: idle cycles with busy data change nothing
    cur_req = "R9";
    for (int i = 0; i < 6; i++) step(0, 4000, 4000, 0);
    chk("R9", "avg held", int'(avg_value), 300);

    // R7: random mix, limits changed only at reset points
    cur_req = "R7";
    for (int blk = 0; blk < 8; blk++) begin
      int lo = 50 + int'($urandom % 100);
      int hi = lo + 50 + int'($urandom % 150);
      do_reset(lo, hi, 80 + int'($urandom % 60), int'($urandom % 7));
      for (int i = 0; i < 500; i++) begin
        int c = int'($urandom % 10);
        int vv = (c < 3) ? int'($urandom % 450) : lo + int'($urandom % (hi - lo + 1));
        step(($urandom % 10) < 7, vv, int'($urandom % 160), ($urandom % 10) == 0);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule